// File: doc/BRIEF.md
# Consecutive Character Pattern Detector

This block sits beside the path that carries received bytes from a serial controller into a receive FIFO. It watches each byte as it is written and keeps a running length of the current run of bytes equal to a programmable character. When that run reaches a programmable length, it sets a sticky status flag. The flag drives an interrupt request. A typical use is to spot the closing characters of a byte-synchronous frame without polling the FIFO.

Software programs the match character and the required run length. It turns detection on with an enable bit and clears the flag with a one-cycle clear pulse. A receive-FIFO reset also clears the flag and the running count. Cycles with no byte strobe do not break a run. Only a byte that differs from the character ends a run.

Top module: `char_run_detect`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `pat_flag` is 0.
- R2: With `det_en` high and `pat_count` nonzero, `pat_flag` reads 1 one clock after the strobe (`byte_vld` high) that brings the run of consecutive bytes equal to `pat_char` up to `pat_count`. Cycles with `byte_vld` low neither extend nor break a run.
- R3: A strobed byte that differs from `pat_char` resets the run length to zero. A new detection then needs `pat_count` further matching bytes.
- R4: When `pat_count` is 0, `pat_flag` is never set, however many matching bytes arrive.
- R5: While `det_en` is low, `pat_flag` is not set and the run length is held at zero. After re-enabling, a full `pat_count` matches are needed.
- R6: `pat_flag` stays 1 until a cycle with `stat_clr` high, and reads 0 the clock after that. If a detection and `stat_clr` happen in the same cycle, the flag ends up 1.
- R7: The run length saturates at `pat_count`. Further matching bytes neither wrap it nor set the flag again after a clear. Only a run that restarts (after a differing byte, a FIFO reset or disabling) can set the flag again.
- R8: A cycle with `fifo_rst` high clears `pat_flag` on the next clock, clears the run length, and overrides any detection in that cycle.
- R9: The run-length limits 1 and 255 both work. With `pat_count` = 1, the first matching byte sets the flag. With `pat_count` = 255, 254 matches leave the flag clear and the 255th sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| byte_vld | input | 1 | A received byte is being written into the FIFO this cycle |
| byte_data | input | 8 | The byte being written |
| pat_char | input | 8 | Character to match |
| pat_count | input | 8 | Required run length; 0 turns detection off |
| det_en | input | 1 | Detection enable |
| fifo_rst | input | 1 | Receive FIFO reset; returns the detector to idle |
| stat_clr | input | 1 | One-cycle pulse that clears the status flag |
| pat_flag | output | 1 | Sticky detection status, used as interrupt request |

## Verification
The assertions assume that all inputs are synchronous to `clk` and hold steady through each rising edge. They also assume that `pat_char` and `pat_count` do not change while a run is being counted: the saturation check compares the run against the limit seen in the same cycle. The stimulus changes inputs only on falling edges. It reprograms the character and run length only after a FIFO reset has returned the detector to idle. Clear and FIFO-reset pulses last one cycle each.

// File: rtl/crd_pkg.sv
package crd_pkg;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned CNT_W  = 8;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/crd_run_counter.sv
module crd_run_counter
  import crd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  logic  en,
  input  logic  vld,
  input  data_t data,
  input  data_t match_char,
  input  cnt_t  limit,
  output logic  hit,
  output cnt_t  run_len
);
  localparam int unsigned EXT_W = CNT_W + 1;

  cnt_t       run_q;
  cnt_t       run_d;
  logic       run_ce;
  logic       is_match;
  logic       at_limit;
  logic [EXT_W-1:0] run_plus1;

  assign is_match  = (data == match_char);
  assign at_limit  = (run_q >= limit);
  assign run_plus1 = {1'b0, run_q} + {{CNT_W{1'b0}}, 1'b1};

  // next-state
  always_comb begin
    run_ce = 1'b0;
    run_d  = run_q;
    hit    = 1'b0;
    if (flush || !en) begin
      run_ce = (run_q != '0);
      run_d  = '0;
    end else if (vld) begin
      run_ce = 1'b1;
      if (!is_match) begin
        run_d = '0;
      end else if (at_limit) begin
        run_d = run_q;
      end else begin
        run_d = run_plus1[CNT_W-1:0];
        hit   = (limit != '0) && (run_plus1 == {1'b0, limit});
      end
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (run_ce) begin
      run_q <= run_d;
    end
  end

  assign run_len = run_q;

  a_r3_mismatch_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vld && !is_match) |=> (run_len == '0));

  a_r5_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (run_len == '0));

  a_r7_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !flush && vld && is_match && (run_len >= limit)) |=> $stable(run_len));

  a_r8_flush_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (run_len == '0));
endmodule

// File: rtl/crd_status_latch.sv
module crd_status_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  logic flag_q;
  logic flag_d;

  // next-state: flush first, then set beats clear
  always_comb begin
    flag_d = flag_q;
    if (flush)        flag_d = 1'b0;
    else if (set_evt) flag_d = 1'b1;
    else if (clr_evt) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_evt && !flush) |=> flag);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && !flush) |=> flag);

  a_r8_flush_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flag);
endmodule

// File: rtl/char_run_detect.sv
module char_run_detect
  import crd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic [DATA_W-1:0] pat_char,
  input  logic [CNT_W-1:0]  pat_count,
  input  logic              det_en,
  input  logic              fifo_rst,
  input  logic              stat_clr,
  output logic              pat_flag
);
  logic hit;
  cnt_t run_len;

  crd_run_counter u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (fifo_rst),
    .en         (det_en),
    .vld        (byte_vld),
    .data       (byte_data),
    .match_char (pat_char),
    .limit      (pat_count),
    .hit        (hit),
    .run_len    (run_len)
  );

  crd_status_latch u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (fifo_rst),
    .set_evt (hit),
    .clr_evt (stat_clr),
    .flag    (pat_flag)
  );

  a_r2_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !fifo_rst) |=> pat_flag);

  a_r4_zero_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((pat_count == '0) && !pat_flag) |=> !pat_flag);

  a_r5_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && !pat_flag) |=> !pat_flag);

  a_r7_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
    ((run_len >= pat_count) && !pat_flag) |=> !pat_flag);

  a_r1_reset_clear: assert property (@(posedge clk)
    (!rst_n) |=> !pat_flag);
endmodule

// File: tb/char_run_detect_tb.sv
module char_run_detect_tb;
  logic       clk;
  logic       rst_n;
  logic       byte_vld;
  logic [7:0] byte_data;
  logic [7:0] pat_char;
  logic [7:0] pat_count;
  logic       det_en;
  logic       fifo_rst;
  logic       stat_clr;
  logic       pat_flag;

  int n_chk;
  int n_fail;
  bit done;

  char_run_detect u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .pat_char  (pat_char),
    .pat_count (pat_count),
    .det_en    (det_en),
    .fifo_rst  (fifo_rst),
    .stat_clr  (stat_clr),
    .pat_flag  (pat_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {vld, clr, expected flag, data}; char 0x7E, run length 3
  localparam int NV = 15;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 8'h7E},
    {1'b1, 1'b0, 1'b0, 8'h7E},
    {1'b1, 1'b0, 1'b0, 8'h55},
    {1'b1, 1'b0, 1'b0, 8'h7E},
    {1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 1'b0, 1'b0, 8'h7E},
    {1'b1, 1'b0, 1'b1, 8'h7E},
    {1'b1, 1'b0, 1'b1, 8'h7E},
    {1'b0, 1'b1, 1'b0, 8'h00},
    {1'b1, 1'b0, 1'b0, 8'h7E},
    {1'b1, 1'b0, 1'b0, 8'h55},
    {1'b1, 1'b0, 1'b0, 8'h7E},
    {1'b1, 1'b0, 1'b0, 8'h7E},
    {1'b1, 1'b0, 1'b1, 8'h7E},
    {1'b1, 1'b1, 1'b0, 8'h7E}
  };

  task automatic check(input logic exp, input string req, input string what);
    n_chk++;
    if (pat_flag !== exp) begin
      n_fail++;
      $display("FAIL %s %s: pat_flag=%b expected=%b", req, what, pat_flag, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [7:0] d, input logic c, input logic fr);
    @(negedge clk);
    byte_vld  = v;
    byte_data = d;
    stat_clr  = c;
    fifo_rst  = fr;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_flush();
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    #(5 * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; byte_vld = 1'b0; byte_data = 8'h00; stat_clr = 1'b0;
    fifo_rst = 1'b0; det_en = 1'b1; pat_char = 8'h7E; pat_count = 8'd3;
    repeat (3) @(posedge clk);
    #1 check(1'b0, "R1", "during reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check(1'b0, "R1", "after release");

    // table walk: R2 R3 R6 R7
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][10], VEC[i][7:0], VEC[i][9], 1'b0);
      check(VEC[i][8], "R2/R3/R6/R7", $sformatf("vector %0d", i));
    end

    // R4: zero run length never fires
    idle_flush();
    pat_count = 8'd0;
    for (int i = 0; i < 5; i++) cyc(1'b1, 8'h7E, 1'b0, 1'b0);
    check(1'b0, "R4", "zero count");

    // R5: disabled, then re-enable needs full run
    idle_flush();
    pat_count = 8'd3;
    det_en = 1'b0;
    for (int i = 0; i < 3; i++) cyc(1'b1, 8'h7E, 1'b0, 1'b0);
    check(1'b0, "R5", "disabled");
    det_en = 1'b1;
    cyc(1'b1, 8'h7E, 1'b0, 1'b0);
    cyc(1'b1, 8'h7E, 1'b0, 1'b0);
    check(1'b0, "R5", "two after re-enable");
    cyc(1'b1, 8'h7E, 1'b0, 1'b0);
    check(1'b1, "R5", "third after re-enable");

    // R8: fifo reset clears flag and run
    cyc(1'b1, 8'h7E, 1'b0, 1'b1);
    check(1'b0, "R8", "flag after fifo reset");
    pat_count = 8'd2;
    cyc(1'b1, 8'h7E, 1'b0, 1'b0);
    check(1'b0, "R8", "run restarted at one");
    cyc(1'b1, 8'h7E, 1'b0, 1'b0);
    check(1'b1, "R8", "run reached two");

    // R9: run length 1, char 0x00, detect together with clear (R6 set wins)
    idle_flush();
    pat_char = 8'h00; pat_count = 8'd1;
    cyc(1'b1, 8'h00, 1'b1, 1'b0);
    check(1'b1, "R9", "count one, set beats clear R6");
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    check(1'b0, "R6", "clear pulse");

    // R9: run length 255, char 0xFF
    idle_flush();
    pat_char = 8'hFF; pat_count = 8'd255;
    for (int i = 0; i < 254; i++) cyc(1'b1, 8'hFF, 1'b0, 1'b0);
    check(1'b0, "R9", "254 of 255");
    cyc(1'b1, 8'hFF, 1'b0, 1'b0);
    check(1'b1, "R9", "255 of 255");
    cyc(1'b1, 8'hFF, 1'b1, 1'b0);
    cyc(1'b1, 8'hFF, 1'b0, 1'b0);
    check(1'b0, "R7", "saturated at 255 no refire");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule